// File: doc/BRIEF.md
# Dual Counter Event Capture Unit

This block takes a snapshot of two live 32-bit counter values, a free-running counter and a prescale up counter, whenever a single-cycle capture strobe arrives. Software reads the snapshots back through a small read port with a registered data output. There are two byte offsets: 0x40 returns the free-running snapshot and 0x44 returns the up-counter snapshot.

Software reads 0x40 first and 0x44 second. Those two values always come from the same capture event, even when further events land between the reads. A read of 0x40 copies the up-counter value of that same event into a hidden shadow register, and 0x44 returns the shadow. Neither snapshot can be written. They change only on a capture strobe.

Top module: `evcap_pair`

## Requirements
- R1: After reset, the free-running snapshot, the up-counter snapshot and the shadow are all zero, so reads of 0x40 and 0x44 both return 0.
- R2: A capture strobe stores `frc_value` into the free-running snapshot, and a later read of offset 0x40 returns it.
- R3: The same strobe stores `upc_value` into the up-counter snapshot. After a read of 0x40, a read of offset 0x44 returns that value.
- R4: A read of 0x40 followed by a read of 0x44 returns values from one capture event, even if another capture strobe occurs between the two reads.
- R5: A strobe in the same cycle as a read of 0x40 has these effects: the read returns the old free-running value, the shadow takes the old up-counter value, and the next ordered pair of reads returns the new event.
- R6: Back-to-back strobes each overwrite both snapshots, so the last strobe's values are the ones read.
- R7: A read of 0x44 that is not preceded by a read of 0x40 returns the last value loaded into the shadow (zero if no 0x40 read has happened since reset). The shadow changes only on a read of 0x40.
- R8: Read data appears on `rd_data` in the cycle after `rd_en`. It holds its value while `rd_en` is low.
- R9: A read of any address other than exactly 0x40 or 0x44 (8-bit byte address) returns zero.
- R10: The snapshots are read-only. Reads never change them, so repeated reads of 0x40 with no strobe in between return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| frc_value | input | 32 | Live free-running counter value |
| upc_value | input | 32 | Live prescale up-counter value |
| cap_evt | input | 1 | Single-cycle capture strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Registered read data |

## Verification
The bench first runs directed sequences, each aimed at one distinction:
- An undisturbed ordered pair of reads checks basic capture.
- A strobe between the two reads separates a shadowed design from one that reads the live up-counter snapshot.
- A strobe in the same cycle as the 0x40 read shows whether the shadow loads the old or the new event.
- A lone 0x44 read shows whether the shadow moves without a preceding 0x40 read.

Near-miss addresses such as 0x41 and 0x48 check that decoding is exact. A long run of random strobes, addresses and counter values is then compared cycle by cycle against a behavioural model.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FRC  = 2'd1,
    SEL_UPC  = 2'd2
  } rd_sel_e;

  // Exact address match against the two mapped offsets; everything else is unmapped.
  function automatic rd_sel_e decode_addr(input logic [31:0] addr,
                                          input logic [31:0] frc_ofs,
                                          input logic [31:0] upc_ofs);
    rd_sel_e sel;
    if (addr == frc_ofs)      sel = SEL_FRC;
    else if (addr == upc_ofs) sel = SEL_UPC;
    else                      sel = SEL_NONE;
    return sel;
  endfunction

endpackage

// File: rtl/evcap_snap.sv
module evcap_snap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic [DATA_W-1:0] frc_in,
  input  logic [DATA_W-1:0] upc_in,
  output logic [DATA_W-1:0] frc_q,
  output logic [DATA_W-1:0] upc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q <= '0;
      upc_q <= '0;
    end else if (cap_evt) begin
      frc_q <= frc_in;
      upc_q <= upc_in;
    end
  end

  AST_FRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> frc_q == $past(frc_in)); // R2
  AST_UPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> upc_q == $past(upc_in)); // R3
  AST_SNAP_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(frc_q) && $stable(upc_q)); // R10

endmodule

// File: rtl/evcap_shadow.sv
module evcap_shadow #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] upc_live,
  output logic [DATA_W-1:0] shadow_q
);

  // Loads the snapshot as it stood before any same-cycle capture (R5).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (load) shadow_q <= upc_live;
  end

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> shadow_q == $past(upc_live)); // R4
  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow_q)); // R7

endmodule

// File: rtl/evcap_rdport.sv
module evcap_rdport
  import evcap_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] FRC_OFS = 32'h40,
  parameter logic [31:0] UPC_OFS = 32'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] frc_snap,
  input  logic [DATA_W-1:0] upc_shadow,
  output logic              shadow_load,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = 32 - ADDR_W;

  rd_sel_e              sel;
  logic [DATA_W-1:0]    mux_d;

  always_comb begin
    sel = decode_addr({{PAD_W{1'b0}}, rd_addr}, FRC_OFS, UPC_OFS);
    unique case (sel)
      SEL_FRC: mux_d = frc_snap;
      SEL_UPC: mux_d = upc_shadow;
      default: mux_d = '0;
    endcase
  end

  assign shadow_load = rd_en && (sel == SEL_FRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mux_d;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sel == SEL_NONE |=> rd_data == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8
  AST_FRC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_load |=> rd_data == $past(frc_snap)); // R2

endmodule

// File: rtl/evcap_pair.sv
module evcap_pair #(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] FRC_OFS = 32'h40,
  parameter logic [31:0] UPC_OFS = 32'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] frc_value,
  input  logic [DATA_W-1:0] upc_value,
  input  logic              cap_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] frc_snap;
  logic [DATA_W-1:0] upc_snap;
  logic [DATA_W-1:0] upc_shadow;
  logic              shadow_load;

  evcap_snap #(.DATA_W(DATA_W)) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_evt(cap_evt),
    .frc_in (frc_value),
    .upc_in (upc_value),
    .frc_q  (frc_snap),
    .upc_q  (upc_snap)
  );

  evcap_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (shadow_load),
    .upc_live(upc_snap),
    .shadow_q(upc_shadow)
  );

  evcap_rdport #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .FRC_OFS(FRC_OFS),
    .UPC_OFS(UPC_OFS)
  ) u_rdport (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .frc_snap   (frc_snap),
    .upc_shadow (upc_shadow),
    .shadow_load(shadow_load),
    .rd_data    (rd_data)
  );

  // The shadow always pairs with the free-running value returned by the same read.
  AST_PAIR_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_load |=> upc_shadow == $past(upc_snap) && rd_data == $past(frc_snap)); // R4
  AST_SAME_CYCLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_load && cap_evt |=> upc_shadow == $past(upc_snap) && upc_snap == $past(upc_value)); // R5

endmodule

// File: tb/evcap_pair_bench.sv
module evcap_pair_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] frc_value = '0;
  logic [31:0] upc_value = '0;
  logic        cap_evt = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  evcap_pair u_evcap_pair (
    .clk(clk), .rst_n(rst_n), .frc_value(frc_value), .upc_value(upc_value),
    .cap_evt(cap_evt), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: read is resolved before a same-cycle capture.
  longint unsigned m_frc, m_upc, m_sh, m_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_frc = 0; m_upc = 0; m_sh = 0; m_rd = 0;
    end else begin
      if (rd_en) begin
        if (rd_addr == 8'h40)      begin m_rd = m_frc; m_sh = m_upc; end
        else if (rd_addr == 8'h44) m_rd = m_sh;
        else                       m_rd = 0;
      end
      if (cap_evt) begin m_frc = frc_value; m_upc = upc_value; end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R8 latency and hold).
  always @(negedge clk) begin
    if (rst_n && !done) check("R8 model", rd_data, m_rd[31:0]);
  end

  task automatic step(bit cap, logic [31:0] f, logic [31:0] u, bit rd, logic [7:0] a);
    cap_evt = cap; frc_value = f; upc_value = u; rd_en = rd; rd_addr = a;
    @(negedge clk);
    cap_evt = 0; rd_en = 0;
  endtask

  task automatic rd(logic [7:0] a);
    step(0, frc_value, upc_value, 1, a);
  endtask

  task automatic cap(logic [31:0] f, logic [31:0] u);
    step(1, f, u, 0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset", rd_data, 32'h0);
    rd(8'h40); check("R1 frc after reset", rd_data, 32'h0);
    rd(8'h44); check("R1 upc after reset", rd_data, 32'h0);

    cap(32'd100, 32'd7);
    rd(8'h40); check("R2", rd_data, 32'd100);
    rd(8'h44); check("R3", rd_data, 32'd7);

    cap(32'd200, 32'd20);
    rd(8'h40); check("R4 first", rd_data, 32'd200);
    cap(32'd300, 32'd30);
    rd(8'h44); check("R4 pair", rd_data, 32'd20);
    rd(8'h40); check("R4 next frc", rd_data, 32'd300);
    rd(8'h44); check("R4 next upc", rd_data, 32'd30);

    step(1, 32'd400, 32'd40, 1, 8'h40); check("R5 old frc", rd_data, 32'd300);
    rd(8'h44); check("R5 old upc", rd_data, 32'd30);
    rd(8'h40); check("R5 new frc", rd_data, 32'd400);
    rd(8'h44); check("R5 new upc", rd_data, 32'd40);

    cap(32'd500, 32'd50);
    cap(32'd600, 32'd60);
    rd(8'h40); check("R6 frc", rd_data, 32'd600);
    rd(8'h44); check("R6 upc", rd_data, 32'd60);

    cap(32'd700, 32'd70);
    rd(8'h44); check("R7 stale shadow", rd_data, 32'd60);
    step(0, 0, 0, 0, 8'h40); check("R8 hold", rd_data, 32'd60);

    rd(8'h48); check("R9 0x48", rd_data, 32'h0);
    rd(8'h41); check("R9 0x41", rd_data, 32'h0);
    rd(8'h00); check("R9 0x00", rd_data, 32'h0);

    rd(8'h40); check("R10 first", rd_data, 32'd700);
    rd(8'h40); check("R10 repeat", rd_data, 32'd700);
    rd(8'h44); check("R10 upc", rd_data, 32'd70);

    for (int i = 0; i < 2000; i++) begin
      logic [7:0] a;
      case ($urandom_range(3))
        0: a = 8'h40;
        1: a = 8'h44;
        2: a = 8'h40;
        default: a = 8'($urandom);
      endcase
      step(1'($urandom_range(1)), $urandom, $urandom, 1'($urandom_range(1)), a);
    end

    finish_run();
  end
endmodule